// File: doc/BRIEF.md
# Prioritized Interrupt Mask Recognizer

This block decides when a CPU sequencer should take an external interrupt. A 3-bit request level arrives from outside the clock domain and is brought in through a two-stage synchronizer. A 3-bit priority mask sits inside an 8-bit condition code register (CCR). Levels 1 to 6 are taken only when they are strictly above that mask. Level 7 ignores the mask. It is taken on a rising edge to 7, and again whenever the request is still at 7 during a return-from-interrupt or a CCR write, even a write that leaves the mask at 7.

When a request is taken, the whole CCR is saved on an internal last-in first-out stack and the mask is raised to the serviced level. A one-cycle pulse carries that level to the sequencer. No further request is taken until the sequencer returns an acknowledge strobe. A return strobe pops the saved CCR back, which restores the earlier mask. Software can overwrite the CCR at any time.

Top module: `prio_irq_gate`

## Requirements
- R1: A request at level 1 to 6 is taken only when its level is strictly greater than the mask, which is CCR bits [7:5].
- R2: When a request is taken, the CCR value from just before acceptance is the value the stack saves. A later return restores exactly that value.
- R3: After acceptance the mask equals the serviced level and CCR bits [4:0] are unchanged. A request held at the same level is not taken again.
- R4: A return strobe replaces the whole CCR with the most recently saved value.
- R5: If software writes a mask below the level of a request that is still held, that request is taken a second time.
- R6: A level-7 request is taken whatever the mask is, and the mask becomes 7.
- R7: A level-7 request that drops and then returns to 7 is taken again.
- R8: A level-7 request still held when a return strobe occurs is taken again.
- R9: A level-7 request held during a CCR write is taken again, even if the value written has mask 7. A steady level-7 request with none of these events is not taken again.
- R10: After reset the CCR is 8'hE0 (mask 7, other bits 0), the stack is empty and no pulse is present.
- R11: Acceptance shows as `takenPulse` high for exactly one cycle with `takenLevel` equal to the serviced level. For level 1 to 6 the pulse is high after the third rising edge after the request changes.
- R12: While an acceptance waits for `ackStrobe`, nothing else is taken. A request that became eligible in that time is taken after the acknowledge.
- R13: The stack holds 8 entries in last-in first-out order. A push onto a full stack overwrites the oldest entry, and a return on an empty stack leaves the CCR unchanged.
- R14: When a return strobe and a CCR write occur in the same cycle, the return wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqLevel | input | 3 | Encoded external request level, asynchronous (0 = none) |
| ccrWrEn | input | 1 | Software write strobe for the CCR |
| ccrWrData | input | 8 | Value written to the CCR |
| rtiStrobe | input | 1 | Return-from-interrupt strobe, pops the stack |
| ackStrobe | input | 1 | Sequencer acknowledge, re-enables acceptance |
| takenPulse | output | 1 | One-cycle acceptance pulse |
| takenLevel | output | 3 | Level of the last acceptance |
| ccrOut | output | 8 | Current condition code register |

## Verification
Every pairing of mask 0..6 with request level 1..6 is swept. This separates the strict greater-than rule from an off-by-one compare and shows that each return restores the full CCR, flag bits included. Level 7 is driven through each event that should take it again: a re-edge, a return, a CCR write of mask 7. A steady hold is also driven, which must not take it again, so an edge-only design and a level-only design both fail. Other runs cover a request held through a mask lowering, acceptance while an acknowledge is outstanding, nine nested saves against the eight-entry stack, and a return colliding with a write. These separate the stack ordering, the overwrite of the oldest entry and the priority between strobes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] NMI_LVL = 3'd7;

  typedef struct packed {
    logic             push;
    logic             pop;
    logic             write;
    logic [LVL_W-1:0] svcLvl;
  } pirqStrobe_t;
endpackage

// File: rtl/pirq_data.sv
module pirq_data
  import pirq_pkg::*;
#(
  parameter int CCR_W    = 8,
  parameter int MASK_LSB = 5,
  parameter int DEPTH    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] reqLevel,
  input  logic [CCR_W-1:0] ccrWrData,
  input  pirqStrobe_t      str,
  output logic [LVL_W-1:0] syncLvl,
  output logic [LVL_W-1:0] prevLvl,
  output logic [LVL_W-1:0] mask,
  output logic [CCR_W-1:0] ccrOut
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CCR_W-1:0] RESET_CCR = CCR_W'(NMI_LVL) << MASK_LSB;
  localparam logic [CCR_W-1:0] MASK_BITS = CCR_W'({LVL_W{1'b1}}) << MASK_LSB;

  logic [LVL_W-1:0] meta;
  logic [CCR_W-1:0] ccr;
  logic [CCR_W-1:0] stackMem [DEPTH];
  logic [PTR_W-1:0] ptr, nextPtr, topPtr;
  logic [CNT_W-1:0] cnt;

  // two-flop synchronizer plus previous-sample register for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta    <= '0;
      syncLvl <= '0;
      prevLvl <= '0;
    end else begin
      meta    <= reqLevel;
      syncLvl <= meta;
      prevLvl <= syncLvl;
    end
  end

  assign nextPtr = (ptr == PTR_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign topPtr  = (ptr == '0) ? PTR_W'(DEPTH - 1) : ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (str.push) stackMem[ptr] <= ccr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
      cnt <= '0;
    end else if (str.push) begin
      ptr <= nextPtr;
      if (cnt != CNT_W'(DEPTH)) cnt <= cnt + 1'b1;
    end else if (str.pop && cnt != '0) begin
      ptr <= topPtr;
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccr <= RESET_CCR;
    end else if (str.pop) begin
      if (cnt != '0) ccr <= stackMem[topPtr];
    end else if (str.write) begin
      ccr <= ccrWrData;
    end else if (str.push) begin
      ccr[MASK_LSB +: LVL_W] <= str.svcLvl;
    end
  end

  assign ccrOut = ccr;
  assign mask   = ccr[MASK_LSB +: LVL_W];

  // R2: the saved entry is the register value before acceptance
  p_push_saves_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.push |=> stackMem[$past(ptr)] == $past(ccr));

  // R3: acceptance touches only the mask field
  p_flags_kept_r3: assert property (@(posedge clk) disable iff (!rstN)
    str.push |=> (ccr & ~MASK_BITS) == $past(ccr & ~MASK_BITS));

  // R13: a return on an empty stack leaves the register alone
  p_empty_pop_r13: assert property (@(posedge clk) disable iff (!rstN)
    (str.pop && cnt == '0) |=> $stable(ccr));
endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
  import pirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] syncLvl,
  input  logic [LVL_W-1:0] prevLvl,
  input  logic [LVL_W-1:0] mask,
  input  logic             ccrWrEn,
  input  logic             rtiStrobe,
  input  logic             ackStrobe,
  output pirqStrobe_t      str,
  output logic             takenPulse,
  output logic [LVL_W-1:0] takenLevel
);
  logic busy, nmiPend;
  logic nmiHeld, nmiEvent, freeSlot, takeNmi, takeLow;

  assign nmiHeld  = (syncLvl == NMI_LVL);
  // an edge to 7, a return or a write while 7 is held re-arms level 7
  assign nmiEvent = (nmiHeld && prevLvl != NMI_LVL) || (nmiHeld && (rtiStrobe || ccrWrEn));
  // returns and writes own the register in their cycle
  assign freeSlot = !busy && !rtiStrobe && !ccrWrEn;
  assign takeNmi  = freeSlot && nmiPend;
  assign takeLow  = freeSlot && !nmiPend && syncLvl != '0 && !nmiHeld && (syncLvl > mask);

  always_comb begin
    str.pop    = rtiStrobe;
    str.write  = ccrWrEn && !rtiStrobe;
    str.push   = takeNmi || takeLow;
    str.svcLvl = takeNmi ? NMI_LVL : syncLvl;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nmiPend    <= 1'b0;
      busy       <= 1'b0;
      takenPulse <= 1'b0;
      takenLevel <= '0;
    end else begin
      nmiPend    <= (nmiPend && !takeNmi) || nmiEvent;
      busy       <= str.push || (busy && !ackStrobe);
      takenPulse <= str.push;
      if (str.push) takenLevel <= str.svcLvl;
    end
  end

  // R11: the acceptance pulse lasts one cycle
  p_one_cycle_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |=> !takenPulse);

  // R1: a maskable level is only taken above the mask it met
  p_above_mask_r1: assert property (@(posedge clk) disable iff (!rstN)
    (takenPulse && takenLevel != NMI_LVL) |-> takenLevel > $past(mask));

  // R3, R6: the mask shows the serviced level together with the pulse
  p_mask_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    takenPulse |-> mask == takenLevel);

  // R12: nothing is taken while an acknowledge is outstanding
  p_wait_ack_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ackStrobe) |=> !takenPulse);
endmodule

// File: rtl/prio_irq_gate.sv
module prio_irq_gate
  import pirq_pkg::*;
#(
  parameter int CCR_W    = 8,
  parameter int MASK_LSB = 5,
  parameter int DEPTH    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       reqLevel,
  input  logic             ccrWrEn,
  input  logic [CCR_W-1:0] ccrWrData,
  input  logic             rtiStrobe,
  input  logic             ackStrobe,
  output logic             takenPulse,
  output logic [2:0]       takenLevel,
  output logic [CCR_W-1:0] ccrOut
);
  pirqStrobe_t      str;
  logic [LVL_W-1:0] syncLvl, prevLvl, mask;

  pirq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .syncLvl(syncLvl), .prevLvl(prevLvl), .mask(mask),
    .ccrWrEn(ccrWrEn), .rtiStrobe(rtiStrobe), .ackStrobe(ackStrobe),
    .str(str), .takenPulse(takenPulse), .takenLevel(takenLevel)
  );

  pirq_data #(.CCR_W(CCR_W), .MASK_LSB(MASK_LSB), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .reqLevel(reqLevel), .ccrWrData(ccrWrData), .str(str),
    .syncLvl(syncLvl), .prevLvl(prevLvl), .mask(mask), .ccrOut(ccrOut)
  );
endmodule

// File: tb/sim_prio_irq_gate.sv
`timescale 1ns/1ps
module sim_prio_irq_gate;
  logic clk = 1'b0, rstN = 1'b0;
  logic [2:0] reqLevel = '0;
  logic ccrWrEn = 1'b0, rtiStrobe = 1'b0, ackStrobe = 1'b0;
  logic [7:0] ccrWrData = '0;
  logic takenPulse;
  logic [2:0] takenLevel;
  logic [7:0] ccrOut;

  int total = 0, failed = 0, pulseCount = 0;
  logic [2:0] lastLevel = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_irq_gate u0 (
    .clk(clk), .rstN(rstN), .reqLevel(reqLevel), .ccrWrEn(ccrWrEn), .ccrWrData(ccrWrData),
    .rtiStrobe(rtiStrobe), .ackStrobe(ackStrobe), .takenPulse(takenPulse),
    .takenLevel(takenLevel), .ccrOut(ccrOut)
  );

  always @(negedge clk) if (takenPulse) begin
    pulseCount++;
    lastLevel = takenLevel;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCcr(input logic [7:0] v);
    ccrWrEn = 1'b1; ccrWrData = v;
    @(negedge clk);
    ccrWrEn = 1'b0;
  endtask

  task automatic rti();
    rtiStrobe = 1'b1;
    @(negedge clk);
    rtiStrobe = 1'b0;
  endtask

  task automatic ack();
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
  endtask

  task automatic expectTake(input logic [2:0] lvl, input bit doAck, input string tag);
    pulseCount = 0;
    cycles(6); #1;
    check(pulseCount == 1 && lastLevel == lvl, tag, pulseCount * 16 + lastLevel, 16 + lvl);
    if (doAck) ack();
  endtask

  task automatic expectNone(input string tag);
    pulseCount = 0;
    cycles(6); #1;
    check(pulseCount == 0, tag, pulseCount, 0);
  endtask

  task automatic checkCcr(input logic [7:0] exp, input string tag);
    check(ccrOut == exp, tag, ccrOut, exp);
  endtask

  task automatic dropReq();
    reqLevel = '0;
    cycles(3);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    // R10 reset state
    checkCcr(8'hE0, "R10 reset ccr");
    check(takenPulse == 1'b0, "R10 reset pulse", takenPulse, 0);

    // R1: mask 7 blocks a maskable level
    reqLevel = 3'd3;
    expectNone("R1 mask7 blocks level3");
    dropReq();

    // R11 exact latency: pulse after the third rising edge
    writeCcr(8'h00);
    cycles(2);
    reqLevel = 3'd4;
    cycles(2); #1;
    check(takenPulse == 1'b0, "R11 no early pulse", takenPulse, 0);
    @(negedge clk); #1;
    check(takenPulse == 1'b1 && takenLevel == 3'd4, "R11 pulse timing", {takenPulse, takenLevel}, 12);
    @(negedge clk); #1;
    check(takenPulse == 1'b0, "R11 single cycle", takenPulse, 0);
    ack();
    checkCcr(8'h80, "R3 mask raised to 4");
    expectNone("R3 held level not retaken");
    dropReq();
    rti();
    checkCcr(8'h00, "R4 restore after latency test");

    // R1 R2 R3 R4 sweep of mask against level
    for (int m = 0; m < 7; m++) begin
      for (int l = 1; l < 7; l++) begin
        logic [7:0] orig;
        orig = {3'(m), 5'(m * 6 + l)};
        dropReq();
        writeCcr(orig);
        reqLevel = 3'(l);
        if (l > m) begin
          expectTake(3'(l), 1'b1, "R1 sweep take");
          checkCcr({3'(l), orig[4:0]}, "R3 sweep mask");
          dropReq();
          rti();
          checkCcr(orig, "R2 R4 sweep restore");
        end else begin
          expectNone("R1 sweep blocked");
          checkCcr(orig, "R1 sweep ccr untouched");
        end
      end
    end

    // R5: lowering the mask under a held request
    dropReq();
    writeCcr(8'h20);
    reqLevel = 3'd4;
    expectTake(3'd4, 1'b1, "R5 first take");
    writeCcr(8'h40);
    expectTake(3'd4, 1'b1, "R5 second take");
    dropReq();
    rti();
    checkCcr(8'h40, "R5 first pop");
    rti();
    checkCcr(8'h20, "R5 second pop");

    // R6 to R9: level seven
    writeCcr(8'h00);
    reqLevel = 3'd7;
    expectTake(3'd7, 1'b1, "R6 level7 taken");
    checkCcr(8'hE0, "R6 mask set to 7");
    expectNone("R9 steady level7 not retaken");
    dropReq();
    reqLevel = 3'd7;
    expectTake(3'd7, 1'b1, "R7 reassert retaken");
    rti();
    expectTake(3'd7, 1'b1, "R8 held through return");
    writeCcr(8'hE0);
    expectTake(3'd7, 1'b1, "R9 write of mask 7 retakes");
    expectNone("R9 steady after write");
    dropReq();
    rti(); rti(); rti();
    checkCcr(8'h00, "R4 level7 nest unwound");

    // R12: acknowledge gating
    reqLevel = 3'd5;
    expectTake(3'd5, 1'b0, "R12 first take");
    writeCcr(8'h01);
    expectNone("R12 blocked while waiting ack");
    ack();
    expectTake(3'd5, 1'b1, "R12 taken after ack");
    checkCcr(8'hA1, "R12 mask after second take");
    dropReq();
    // R14: return beats a write in the same cycle
    rtiStrobe = 1'b1; ccrWrEn = 1'b1; ccrWrData = 8'hFF;
    @(negedge clk);
    rtiStrobe = 1'b0; ccrWrEn = 1'b0;
    checkCcr(8'h01, "R14 write dropped on return");
    rti();
    checkCcr(8'h00, "R4 after collision");

    // R13: overflow of the eight-entry stack
    writeCcr(8'hE0);
    reqLevel = 3'd6;
    expectNone("R1 level6 under mask7");
    for (int k = 1; k <= 9; k++) begin
      writeCcr({3'd0, 5'(k)});
      expectTake(3'd6, 1'b1, "R13 nested take");
      checkCcr({3'd6, 5'(k)}, "R13 mask after take");
    end
    dropReq();
    for (int j = 1; j <= 8; j++) begin
      rti();
      checkCcr({3'd0, 5'(10 - j)}, "R13 lifo pop");
    end
    rti();
    checkCcr(8'h02, "R13 empty pop unchanged");

    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule